// File: doc/BRIEF.md
# Bus-Master Ownership Arbiter

This block is the central arbiter for a shared bus with several bus-master devices connected in a star. Each master has three private wires: a request it raises when it wants the bus, a grant the arbiter drives back, and a busy level the master holds for as long as it is actually driving the bus. The arbiter grants the bus to one master at a time. It can take the bus back by withdrawing the grant, and it hands the bus to the next master only after every busy line has fallen.

Three service orders can be selected. In the fixed order, master 0 always wins. In the rotating order, the master that was just served drops to the lowest place. In the round-robin order, a pointer steps forward once per tenure and the search skips idle inputs. A hold limit caps how long one tenure may last. The order and the limit are loaded through a small configuration port. That port is honoured only while no grant is out.

Top module: `busmaster_arbiter`

## Requirements
- R1: While reset is applied, and for the two clock edges after its release (reset is released synchronously), every grant output is low.
- R2: At most one grant is high at any time. A new grant is issued only at an edge where every busy input is low.
- R3: When no grant is out and all busy lines are low, the highest-ranked pending request receives its grant at the next clock edge.
- R4: The owner keeps its grant while its request stays high. Once its request is low at an edge, the grant is low after that edge.
- R5: If a request ranked above the owner is pending at an edge, the owner's grant is withdrawn at that edge. The grant for the new master comes only after all busy lines are low. A grant never moves directly from one master to another.
- R6: A pending request ranked below the current owner does not disturb the owner's grant.
- R7: Mode code 0 (and the spare code 3) is the fixed order: input 0 ranks highest and input 3 lowest, always.
- R8: Mode code 1 is rotating. When the grant of master k is withdrawn, the top rank moves to input k+1 (mod 4) and the others follow cyclically. After serving 2, the order is 3, 0, 1, 2.
- R9: Mode code 2 is round robin. The search start pointer advances by exactly one input each time a grant is withdrawn, and the search skips inputs with no request.
- R10: With a non-zero hold limit L, no grant stays high for more than L consecutive cycles. A limit of 0 means no limit.
- R11: A configuration load (mode and limit) takes effect only at an edge where no grant is out. Such a load returns the pointer to input 0. A load while a grant is high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | N_MASTERS | Per-master bus request levels |
| busy_i | input | N_MASTERS | Per-master bus-busy levels, high while a master drives the bus |
| gnt_o | output | N_MASTERS | Per-master grant, at most one high |
| cfg_load_i | input | 1 | Load strobe for mode and hold limit |
| cfg_mode_i | input | 2 | Discipline code: 0 fixed, 1 rotating, 2 round robin, 3 fixed |
| cfg_limit_i | input | HOLD_W | Hold limit in cycles, 0 for unlimited |

## Verification
Every grant decision is registered once. A grant or a withdrawal therefore shows on `gnt_o` one edge after the request, busy or limit condition that caused it. Because busy follows the grant, a handover from one master to another takes two edges. A configuration load affects only decisions made after the edge that stores it. The bench drives inputs on the falling edge and advances a behavioural model on the rising edge. It compares `gnt_o` with the model at the following falling edge, so each result is sampled in the cycle it is due. Scenario checks count those same edges by hand: one for a grant, one for a withdrawal, one more per cycle of stretched busy, and L high cycles for a hold limit of L.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    ARB_FIXED  = 2'd0,
    ARB_ROTATE = 2'd1,
    ARB_RROBIN = 2'd2,
    ARB_FIXED2 = 2'd3
  } arb_mode_e;
endpackage

// File: rtl/arb_pick.sv
// Scans pending requests starting at the top-ranked input and returns
// the first one found together with its rank (distance from the top).
module arb_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] top_i,
  output logic          valid_o,
  output logic [IW-1:0] win_o,
  output logic [IW-1:0] rank_o
);
  always_comb begin
    int idx;
    valid_o = 1'b0;
    win_o   = '0;
    rank_o  = '0;
    idx     = 0;
    for (int off = 0; off < N; off++) begin
      idx = (int'(top_i) + off) % N;
      if (!valid_o && req_i[idx]) begin
        valid_o = 1'b1;
        win_o   = IW'(idx);
        rank_o  = IW'(off);
      end
    end
  end
endmodule

// File: rtl/arb_hold_timer.sv
// Counts cycles of one tenure; flags the last allowed cycle.
module arb_hold_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         run_i,
  input  logic [W-1:0] limit_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr_i || (run_i && (cnt_q != '1));
    cnt_d  = clr_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire_o = run_i && (limit_i != '0) && (cnt_q == limit_i - W'(1));
endmodule

// File: rtl/arb_rst_sync.sv
// Asynchronous assertion, synchronous two-flop release.
module arb_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_no = s2_q;
endmodule

// File: rtl/busmaster_arbiter.sv
module busmaster_arbiter
  import arb_pkg::*;
#(
  parameter int N_MASTERS = 4,
  parameter int HOLD_W    = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_MASTERS-1:0] req_i,
  input  logic [N_MASTERS-1:0] busy_i,
  output logic [N_MASTERS-1:0] gnt_o,
  input  logic                 cfg_load_i,
  input  logic [1:0]           cfg_mode_i,
  input  logic [HOLD_W-1:0]    cfg_limit_i
);
  localparam int IW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1;

  logic                 rst_sync_n;
  logic [N_MASTERS-1:0] gnt_q, gnt_d;
  logic [IW-1:0]        owner_q, owner_d;
  logic [IW-1:0]        top_q, top_d;
  arb_mode_e            mode_q, mode_d;
  logic [HOLD_W-1:0]    limit_q, limit_d;

  logic          granted, any_busy, grant_new, release_now, cfg_en, top_en;
  logic          pick_valid, preempt, owner_req, expire;
  logic [IW-1:0] pick_win, pick_rank, owner_rank;

  function automatic logic [IW-1:0] wrap_inc(input logic [IW-1:0] x);
    return IW'((int'(x) + 1) % N_MASTERS);
  endfunction

  arb_rst_sync u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_sync_n)
  );

  arb_pick #(.N(N_MASTERS), .IW(IW)) u_pick (
    .req_i  (req_i),
    .top_i  (top_q),
    .valid_o(pick_valid),
    .win_o  (pick_win),
    .rank_o (pick_rank)
  );

  arb_hold_timer #(.W(HOLD_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .clr_i   (grant_new),
    .run_i   (granted),
    .limit_i (limit_q),
    .expire_o(expire)
  );

  always_comb begin
    granted     = |gnt_q;
    any_busy    = |busy_i;
    owner_req   = req_i[owner_q];
    owner_rank  = IW'((int'(owner_q) + N_MASTERS - int'(top_q)) % N_MASTERS);
    preempt     = pick_valid && (pick_rank < owner_rank);
    release_now = granted && (!owner_req || expire || preempt);
    grant_new   = !granted && !any_busy && pick_valid;
    cfg_en      = !granted && cfg_load_i;

    gnt_d   = gnt_q;
    owner_d = owner_q;
    mode_d  = arb_mode_e'(cfg_mode_i);
    limit_d = cfg_limit_i;
    top_d   = top_q;

    if (grant_new) begin
      gnt_d           = '0;
      gnt_d[pick_win] = 1'b1;
      owner_d         = pick_win;
    end else if (release_now) begin
      gnt_d = '0;
    end

    if (cfg_en) begin
      top_d = '0;
    end else if (release_now) begin
      case (mode_q)
        ARB_ROTATE: top_d = wrap_inc(owner_q);
        ARB_RROBIN: top_d = wrap_inc(top_q);
        default:    top_d = '0;
      endcase
    end
    top_en = cfg_en || release_now;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      gnt_q   <= '0;
      owner_q <= '0;
    end else begin
      gnt_q <= gnt_d;
      if (grant_new) owner_q <= owner_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_q  <= ARB_FIXED;
      limit_q <= '0;
      top_q   <= '0;
    end else begin
      if (cfg_en) begin
        mode_q  <= mode_d;
        limit_q <= limit_d;
      end
      if (top_en) top_q <= top_d;
    end
  end

  assign gnt_o = gnt_q;
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int N  = 4,
  parameter int HW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [N-1:0]  req_i,
  input logic [N-1:0]  busy_i,
  input logic [N-1:0]  gnt_i,
  input logic [1:0]    mode_i,
  input logic [HW-1:0] limit_i
);
  logic [HW:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              run_q <= '0;
    else if (gnt_i == '0)     run_q <= '0;
    else if (run_q != '1)     run_q <= run_q + 1'b1;
  end

  // R2
  one_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_i));

  // R2
  idle_bus_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_i != '0 && $past(gnt_i) == '0) |-> ($past(busy_i) == '0));

  // R5
  no_direct_handover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(gnt_i) != '0 && gnt_i != $past(gnt_i)) |-> (gnt_i == '0));

  // R4
  drop_on_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_i & ~req_i) != '0) |=> (gnt_i == '0));

  // R10
  hold_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_i != '0 && limit_i != '0) |-> (run_q < {1'b0, limit_i}));

  // R11
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_i != '0) |=> ($stable(mode_i) && $stable(limit_i)));
endmodule

bind busmaster_arbiter arb_checker #(.N(N_MASTERS), .HW(HOLD_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_sync_n),
  .req_i  (req_i),
  .busy_i (busy_i),
  .gnt_i  (gnt_o),
  .mode_i (mode_q),
  .limit_i(limit_q)
);

// File: tb/sim_busmaster_arbiter.sv
module sim_busmaster_arbiter;
  localparam int  N          = 4;
  localparam int  HW         = 8;
  localparam time CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic [N-1:0]  req = '0, busy = '0, extra = '0;
  logic [N-1:0]  gnt;
  logic          cfg_load = 1'b0;
  logic [1:0]    cfg_mode = '0;
  logic [HW-1:0] cfg_limit = '0;

  int    n_chk = 0, n_fail = 0;
  bit    done = 0;
  string cur = "R1";

  // behavioural reference state
  int m_gnt = -1, m_top = 0, m_mode = 0, m_lim = 0, m_cnt = 0, m_sync = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  busmaster_arbiter #(.N_MASTERS(N), .HOLD_W(HW)) u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .req_i      (req),
    .busy_i     (busy),
    .gnt_o      (gnt),
    .cfg_load_i (cfg_load),
    .cfg_mode_i (cfg_mode),
    .cfg_limit_i(cfg_limit)
  );

  function automatic int rk(int i);
    return (i - m_top + N) % N;
  endfunction

  function automatic int m_pick();
    for (int off = 0; off < N; off++)
      if (req[(m_top + off) % N]) return (m_top + off) % N;
    return -1;
  endfunction

  task automatic m_reset();
    m_gnt = -1; m_top = 0; m_mode = 0; m_lim = 0; m_cnt = 0;
  endtask

  always @(posedge clk) begin
    int  w;
    bit  rel;
    if (!rst_n) begin
      m_sync = 0; m_reset();
    end else if (m_sync < 2) begin
      m_sync++; m_reset();
    end else begin
      w = m_pick();
      if (m_gnt < 0) begin
        if (busy == '0 && w >= 0) begin m_gnt = w; m_cnt = 0; end
        if (cfg_load) begin m_mode = int'(cfg_mode); m_lim = int'(cfg_limit); m_top = 0; end
      end else begin
        rel = !req[m_gnt] || (m_lim != 0 && m_cnt == m_lim - 1) || (w >= 0 && rk(w) < rk(m_gnt));
        m_cnt++;
        if (rel) begin
          if (m_mode == 1)      m_top = (m_gnt + 1) % N;
          else if (m_mode == 2) m_top = (m_top + 1) % N;
          else                  m_top = 0;
          m_gnt = -1;
        end
      end
    end
  end

  function automatic logic [N-1:0] m_vec();
    return (m_gnt < 0) ? '0 : (N'(1) << m_gnt);
  endfunction

  // one cycle: compare against the model at the falling edge, then drive busy
  task automatic tick();
    @(negedge clk);
    n_chk++;
    if (gnt !== m_vec()) begin
      n_fail++;
      $display("FAIL %s: gnt=%b expected %b at %0t", cur, gnt, m_vec(), $time);
    end
    busy = gnt | extra;
  endtask

  task automatic expect_now(input logic [N-1:0] exp, input string tag);
    n_chk++;
    if (gnt !== exp) begin
      n_fail++;
      $display("FAIL %s: gnt=%b expected %b at %0t", tag, gnt, exp, $time);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic set_cfg(input logic [1:0] md, input logic [HW-1:0] lim);
    cfg_mode = md; cfg_limit = lim; cfg_load = 1'b1;
    tick();
    cfg_load = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int run;
    #1 rst_n = 1'b0;
    // R1: grants low during reset and the synchronous release
    cur = "R1";
    req = 4'b1111;
    ticks(2);
    expect_now(4'b0000, "R1 in reset");
    rst_n = 1'b1;
    tick();
    expect_now(4'b0000, "R1 release edge");
    req = '0;
    ticks(3);

    // R7 / R3: fixed order, 1 beats 3
    cur = "R7";
    req = 4'b1010;
    tick();
    expect_now(4'b0010, "R7 fixed picks input 1");
    // R6: lower-ranked 3 waits
    cur = "R6";
    ticks(3);
    expect_now(4'b0010, "R6 owner kept against lower rank");
    // R4: owner drops request
    cur = "R4";
    req[1] = 1'b0;
    tick();
    expect_now(4'b0000, "R4 grant withdrawn after request drop");
    tick();
    expect_now(4'b1000, "R3 next pending granted");

    // R5: preemption by 0, owner busy stretched one extra cycle
    cur = "R5";
    req[0] = 1'b1; extra = 4'b1000;
    tick();
    expect_now(4'b0000, "R5 owner withdrawn by higher rank");
    tick();
    expect_now(4'b0000, "R5 no grant while busy high");
    extra = '0; busy = gnt;
    tick();
    expect_now(4'b0001, "R5 preempting master granted");
    req = '0;
    ticks(3);

    // R2: stray busy blocks a grant
    cur = "R2";
    extra = 4'b0100; busy = extra;
    req = 4'b0001;
    ticks(4);
    expect_now(4'b0000, "R2 no grant while any busy");
    extra = '0; busy = gnt;
    ticks(2);
    expect_now(4'b0001, "R2 grant after busy clears");
    req = '0;
    ticks(3);

    // R10: hold limit of 5
    cur = "R10";
    set_cfg(2'd0, 8'd5);
    req = 4'b0100;
    tick();
    run = 0;
    while (gnt[2] && run < 40) begin run++; tick(); end
    n_chk++;
    if (run != 5) begin
      n_fail++;
      $display("FAIL R10: tenure=%0d expected %0d", run, 5);
    end
    ticks(8);
    req = '0;
    ticks(3);

    // R8: rotating, after 2 the order is 3,0,1,2
    cur = "R8";
    set_cfg(2'd1, 8'd0);
    req = 4'b0100;
    ticks(2);
    expect_now(4'b0100, "R8 input 2 served");
    req = 4'b1001;
    ticks(2);
    expect_now(4'b1000, "R8 input 3 now top after 2");
    req = '0;
    ticks(3);

    // R9: round robin pointer steps by one
    cur = "R9";
    set_cfg(2'd2, 8'd0);
    req = 4'b0100;
    ticks(2);
    expect_now(4'b0100, "R9 idle 0 and 1 skipped");
    req = 4'b1010;
    ticks(2);
    expect_now(4'b0010, "R9 pointer at 1 after one release");

    // R11: load during a grant is ignored (limit 3 must not cut the tenure)
    cur = "R11";
    cfg_mode = 2'd0; cfg_limit = 8'd3; cfg_load = 1'b1;
    tick();
    cfg_load = 1'b0;
    ticks(6);
    expect_now(4'b0010, "R11 load during grant ignored");
    req = '0;
    ticks(3);

    // mixed traffic in every mode
    cur = "R3";
    for (int i = 0; i < 1500; i++) begin
      if (($urandom % 25) == 0) begin
        cfg_load = 1'b1; cfg_mode = 2'($urandom % 4); cfg_limit = HW'($urandom % 8);
      end else begin
        cfg_load = 1'b0;
      end
      req   = N'($urandom);
      extra = (($urandom % 8) == 0) ? N'($urandom) : '0;
      tick();
    end
    cfg_load = 1'b0; req = '0; extra = '0;
    ticks(4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule